// File: doc/BRIEF.md
# Real-Time Clock Sticky Status Flags

This block holds the eight-bit volatile status register of a real-time clock. Hardware event pulses and level indications from the surrounding clock logic come in, and the flags the host reads over a simple register bus go out. Each bit follows its own rules. The two alarm flags are sticky: the host can only clear them, and they can also clear themselves after a read. The daylight-saving flag is driven by forward and reverse events and can be forced by one write code. The power-loss flag is set only after both supplies were lost, and any write to the timekeeping registers clears it. Four bits are live copies of synchronized comparator levels.

A status read is handled by a small state machine with three states: `RD_IDLE`, `RD_HOLD` and `RD_CLEAR`. In `RD_IDLE`, a read strobe addressed to the status register captures a snapshot of the flags and moves the machine to `RD_HOLD` (transition *start*). The snapshot stays on the read data for as long as the strobe stays high. When the strobe drops, the machine goes to `RD_CLEAR` if auto-clear is enabled (transition *finish-clear*) or back to `RD_IDLE` if it is not (transition *finish-plain*). `RD_CLEAR` always returns to `RD_IDLE` after one cycle (transition *retire*). On that edge, only the alarm flags that read as 1 in the snapshot are cleared, so an alarm that fired during the read is kept.

Top module: `rtc_status_flags`

## Requirements
- R1: After reset every flag is 0. The status register sits at address 08h. Read data is 00h whenever no status read is active. The bit layout, from bit 7 to bit 0, is: battery mode, DST-adjusted, alarm 1, alarm 0, main-supply low, battery warning, battery critical, power lost.
- R2: A pulse on `alarm_hit[i]` sets alarm flag i (bit 4+i) on the next edge.
- R3: A host write to 08h with bit 4+i equal to 0 clears alarm flag i. A written 1 leaves the flag unchanged, so a write can never set an alarm flag.
- R4: When a hardware set and a clear (a host write or auto-clear) reach the same alarm bit in the same cycle, the bit ends at 1.
- R5: In `RD_IDLE`, `host_rd` with `host_addr`=08h captures a snapshot and enters `RD_HOLD`. Read data holds the snapshot unchanged while `host_rd` stays high. When `host_rd` falls, the machine enters `RD_CLEAR` if `auto_clr_en`=1 and `RD_IDLE` otherwise. `RD_CLEAR` returns to `RD_IDLE` after one cycle.
- R6: On the edge that leaves `RD_CLEAR`, each alarm flag that read 1 in the snapshot is cleared. An alarm flag set after the snapshot was taken stays set.
- R7: `dst_fwd` sets the DST flag (bit 6) and `dst_rev` clears it. When both arrive together, forward wins. `dst_enable`=0 holds the flag at 0 and overrides every other source.
- R8: A host write of F0h to 08h forces the DST flag to 1 while `dst_enable`=1.
- R9: `pwr_up` sets the power-lost flag (bit 0) only while both `main_lost` and `batt_lost` are 1. A pulse with only one of them high has no effect.
- R10: Any host write to an address from 00h to 07h clears the power-lost flag. Writes to other addresses leave it unchanged. A set in the same cycle wins over the clear.
- R11: Bit 7 reads `on_batt` AND `batt_bus_en`. Bits 3, 2 and 1 follow `main_low_raw`, `batt_warn_raw` and `batt_crit_raw`. The raw inputs pass through two synchronizer stages. Host writes do not affect these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, held high for the length of the read |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status snapshot during a read, otherwise 00h |
| alarm_hit | input | 2 | Alarm match pulses, one per alarm |
| dst_fwd | input | 1 | Forward daylight-saving event pulse |
| dst_rev | input | 1 | Reverse daylight-saving event pulse |
| dst_enable | input | 1 | Daylight-saving function enable |
| auto_clr_en | input | 1 | Clear alarm flags after each status read |
| pwr_up | input | 1 | Power-up event pulse |
| main_lost | input | 1 | Main supply was lost before power-up |
| batt_lost | input | 1 | Battery supply was lost before power-up |
| on_batt | input | 1 | Device runs from battery (asynchronous level) |
| batt_bus_en | input | 1 | Enables the host bus while on battery |
| main_low_raw | input | 1 | Main supply brownout comparator (asynchronous level) |
| batt_warn_raw | input | 1 | Battery below upper trip (asynchronous level) |
| batt_crit_raw | input | 1 | Battery below lower trip (asynchronous level) |

## Verification
The functions that can fall in the same cycle are a hardware set of an alarm flag and its clearing, either by a host write of 0 or by the auto-clear that retires a read. The bench provokes this by pulsing `alarm_hit` in the single `RD_CLEAR` cycle and by pulsing it together with a clearing write. A behavioural model predicts the read data on every clock, and a later read must show the flag still set. The same approach covers a power-up set that coincides with a timekeeping write, and forward and reverse DST events that arrive together.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;

    localparam int STATUS_W   = 8;
    localparam int NUM_ALARMS = 2;
    localparam int LEVEL_W    = 4;

    // bit positions of the status byte (the host decodes these)
    localparam int BIT_LOST   = 0;
    localparam int BIT_CRIT   = 1;
    localparam int BIT_WARN   = 2;
    localparam int BIT_MLOW   = 3;
    localparam int ALARM_LSB  = 4;
    localparam int BIT_DST    = 6;
    localparam int BIT_BMODE  = 7;

    typedef struct packed {
        logic batt_mode;
        logic dst_shifted;
        logic alarm1;
        logic alarm0;
        logic main_low;
        logic batt_warn;
        logic batt_crit;
        logic power_lost;
    } status_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_HOLD  = 2'd1,
        RD_CLEAR = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rtc_level_sync.sv
module rtc_level_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end
            assign q = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rtc_read_fsm.sv
module rtc_read_fsm
    import rtc_status_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int unsigned STATUS_ADDR = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  auto_clr_en,
    input  status_t               live,
    output logic                  rd_active,
    output status_t               snap,
    output logic [NUM_ALARMS-1:0] auto_clr
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

    rd_state_e state_q, state_d;
    logic      start;

    assign start = (state_q == RD_IDLE) && rd_en && (addr == HIT_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, finish-clear, finish-plain, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (start) state_d = RD_HOLD;
            RD_HOLD:  if (!rd_en) state_d = auto_clr_en ? RD_CLEAR : RD_IDLE;
            RD_CLEAR: state_d = RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    // snapshot taken on the start transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     snap <= '0;
        else if (start) snap <= live;
    end

    // outputs
    always_comb begin
        rd_active = 1'b0;
        auto_clr  = '0;
        unique case (state_q)
            RD_IDLE:  ;
            RD_HOLD:  rd_active = 1'b1;
            RD_CLEAR: auto_clr  = {snap.alarm1, snap.alarm0};
            default:  ;
        endcase
    end

endmodule

// File: rtl/rtc_flag_core.sv
module rtc_flag_core
    import rtc_status_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int unsigned STATUS_ADDR   = 8,
    parameter int unsigned RTC_LAST_ADDR = 7,
    parameter logic [7:0]  FORCE_CODE    = 8'hF0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [STATUS_W-1:0]   wdata,
    input  logic [NUM_ALARMS-1:0] alarm_hit,
    input  logic [NUM_ALARMS-1:0] auto_clr,
    input  logic                  dst_fwd,
    input  logic                  dst_rev,
    input  logic                  dst_enable,
    input  logic                  pwr_up,
    input  logic                  main_lost,
    input  logic                  batt_lost,
    output logic [NUM_ALARMS-1:0] alarm_q,
    output logic                  dst_q,
    output logic                  lost_q
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(RTC_LAST_ADDR);

    logic stat_wr, time_wr, force_dst, total_loss;

    assign stat_wr    = wr_en && (addr == STAT_A);
    assign time_wr    = wr_en && (addr <= LAST_A);
    assign force_dst  = stat_wr && (wdata == FORCE_CODE);
    assign total_loss = pwr_up && main_lost && batt_lost;

    // alarm flags: hardware set beats every clear
    generate
        for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
            logic host_clr;
            assign host_clr = stat_wr && !wdata[ALARM_LSB+i];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       alarm_q[i] <= 1'b0;
                else if (alarm_hit[i])            alarm_q[i] <= 1'b1;
                else if (host_clr || auto_clr[i]) alarm_q[i] <= 1'b0;
            end
        end
    endgenerate

    // daylight-saving flag: disable beats set, set beats reverse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      dst_q <= 1'b0;
        else if (!dst_enable)            dst_q <= 1'b0;
        else if (dst_fwd || force_dst)   dst_q <= 1'b1;
        else if (dst_rev)                dst_q <= 1'b0;
    end

    // power-lost flag: set beats the timekeeping-write clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lost_q <= 1'b0;
        else if (total_loss) lost_q <= 1'b1;
        else if (time_wr)    lost_q <= 1'b0;
    end

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtc_status_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int unsigned STATUS_ADDR   = 8,
    parameter int unsigned RTC_LAST_ADDR = 7,
    parameter int          SYNC_STAGES   = 2,
    parameter logic [7:0]  FORCE_CODE    = 8'hF0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    input  logic [1:0]            alarm_hit,
    input  logic                  dst_fwd,
    input  logic                  dst_rev,
    input  logic                  dst_enable,
    input  logic                  auto_clr_en,
    input  logic                  pwr_up,
    input  logic                  main_lost,
    input  logic                  batt_lost,
    input  logic                  on_batt,
    input  logic                  batt_bus_en,
    input  logic                  main_low_raw,
    input  logic                  batt_warn_raw,
    input  logic                  batt_crit_raw
);

    logic [LEVEL_W-1:0]    lvl_q;
    logic [NUM_ALARMS-1:0] alarm_q, auto_clr;
    logic                  dst_q, lost_q, rd_active;
    status_t               live, snap;

    rtc_level_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LEVEL_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({on_batt, main_low_raw, batt_warn_raw, batt_crit_raw}),
        .q     (lvl_q)
    );

    rtc_flag_core #(
        .ADDR_W        (ADDR_W),
        .STATUS_ADDR   (STATUS_ADDR),
        .RTC_LAST_ADDR (RTC_LAST_ADDR),
        .FORCE_CODE    (FORCE_CODE)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .alarm_hit  (alarm_hit),
        .auto_clr   (auto_clr),
        .dst_fwd    (dst_fwd),
        .dst_rev    (dst_rev),
        .dst_enable (dst_enable),
        .pwr_up     (pwr_up),
        .main_lost  (main_lost),
        .batt_lost  (batt_lost),
        .alarm_q    (alarm_q),
        .dst_q      (dst_q),
        .lost_q     (lost_q)
    );

    always_comb begin
        live.batt_mode   = lvl_q[3] & batt_bus_en;
        live.dst_shifted = dst_q;
        live.alarm1      = alarm_q[1];
        live.alarm0      = alarm_q[0];
        live.main_low    = lvl_q[2];
        live.batt_warn   = lvl_q[1];
        live.batt_crit   = lvl_q[0];
        live.power_lost  = lost_q;
    end

    rtc_read_fsm #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (host_rd),
        .addr        (host_addr),
        .auto_clr_en (auto_clr_en),
        .live        (live),
        .rd_active   (rd_active),
        .snap        (snap),
        .auto_clr    (auto_clr)
    );

    assign host_rdata = rd_active ? snap : '0;

endmodule

// File: rtl/rtc_status_flags_chk.sv
module rtc_status_flags_chk
    import rtc_status_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int unsigned STATUS_ADDR   = 8,
    parameter int unsigned RTC_LAST_ADDR = 7,
    parameter logic [7:0]  FORCE_CODE    = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic [1:0]        alarm_hit,
    input logic              dst_enable,
    input logic              pwr_up,
    input logic              main_lost,
    input logic              batt_lost,
    input logic [7:0]        flags,
    input logic              rd_active,
    input logic [1:0]        auto_clr
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(RTC_LAST_ADDR);

    // R1: idle read data is zero
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> host_rdata == 8'h00);

    // R2 and R4: a match always lands, whatever clear coincides
    assert_alarm0_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit[0] |=> flags[ALARM_LSB]);
    assert_alarm1_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit[1] |=> flags[ALARM_LSB+1]);

    // R3: a status write never raises an alarm flag
    assert_write_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == STAT_A && !flags[ALARM_LSB] && !alarm_hit[0])
        |=> !flags[ALARM_LSB]);

    // R5: snapshot held steady during a read
    assert_snap_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |=> (!rd_active || $stable(host_rdata)));

    // R6: auto-clear removes a snapshotted alarm unless a new match arrives
    assert_auto_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr[0] && !alarm_hit[0]) |=> !flags[ALARM_LSB]);

    // R7: disable holds the DST flag at zero
    assert_dst_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_enable |=> !flags[BIT_DST]);

    // R8: force code raises the DST flag
    assert_dst_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_enable && host_wr && host_addr == STAT_A && host_wdata == FORCE_CODE)
        |=> flags[BIT_DST]);

    // R9: power-up after total loss sets the flag; a partial loss does not
    assert_lost_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && main_lost && batt_lost) |=> flags[BIT_LOST]);
    assert_partial_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pwr_up && main_lost && batt_lost) && !flags[BIT_LOST]) |=> !flags[BIT_LOST]);

    // R10: a timekeeping write clears the flag when no set coincides
    assert_lost_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr <= LAST_A && !(pwr_up && main_lost && batt_lost))
        |=> !flags[BIT_LOST]);

endmodule

bind rtc_status_flags rtc_status_flags_chk #(
    .ADDR_W        (ADDR_W),
    .STATUS_ADDR   (STATUS_ADDR),
    .RTC_LAST_ADDR (RTC_LAST_ADDR),
    .FORCE_CODE    (FORCE_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .alarm_hit  (alarm_hit),
    .dst_enable (dst_enable),
    .pwr_up     (pwr_up),
    .main_lost  (main_lost),
    .batt_lost  (batt_lost),
    .flags      (live),
    .rd_active  (rd_active),
    .auto_clr   (auto_clr)
);

// File: tb/tb_rtc_status_flags.sv
module tb_rtc_status_flags;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0;
    logic [7:0] host_addr = 0, host_wdata = 0;
    logic [7:0] host_rdata;
    logic [1:0] alarm_hit = 0;
    logic       dst_fwd = 0, dst_rev = 0, dst_enable = 0, auto_clr_en = 0;
    logic       pwr_up = 0, main_lost = 0, batt_lost = 0;
    logic       on_batt = 0, batt_bus_en = 0;
    logic       main_low_raw = 0, batt_warn_raw = 0, batt_crit_raw = 0;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    done = 0;
    string phase = "R1 reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_status_flags dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .alarm_hit(alarm_hit), .dst_fwd(dst_fwd), .dst_rev(dst_rev),
        .dst_enable(dst_enable), .auto_clr_en(auto_clr_en), .pwr_up(pwr_up),
        .main_lost(main_lost), .batt_lost(batt_lost), .on_batt(on_batt),
        .batt_bus_en(batt_bus_en), .main_low_raw(main_low_raw),
        .batt_warn_raw(batt_warn_raw), .batt_crit_raw(batt_crit_raw)
    );

    // ---------------- behavioural reference ----------------
    int         m_mode;            // 0 idle, 1 reading, 2 retiring
    logic [7:0] m_snap;
    logic [1:0] m_alm;
    logic       m_dst, m_lost;
    logic [3:0] m_s1, m_s2;        // two synchronizer stages {batt, mlow, warn, crit}

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_snap = 0; m_alm = 0; m_dst = 0; m_lost = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            logic [7:0] now;
            logic [1:0] wipe, nalm;
            logic       swr;
            int         nmode;
            now  = {m_s2[3] & batt_bus_en, m_dst, m_alm, m_s2[2:0], m_lost};
            swr  = host_wr && host_addr == 8'h08;
            wipe = (m_mode == 2) ? m_snap[5:4] : 2'b00;
            for (int i = 0; i < 2; i++) begin
                if (alarm_hit[i]) nalm[i] = 1'b1;
                else if ((swr && !host_wdata[4+i]) || wipe[i]) nalm[i] = 1'b0;
                else nalm[i] = m_alm[i];
            end
            nmode = m_mode;
            if (m_mode == 0 && host_rd && host_addr == 8'h08) begin
                nmode = 1; m_snap = now;
            end else if (m_mode == 1 && !host_rd) nmode = auto_clr_en ? 2 : 0;
            else if (m_mode == 2) nmode = 0;
            m_mode = nmode;
            m_alm  = nalm;
            if (!dst_enable) m_dst = 0;
            else if (dst_fwd || (swr && host_wdata == 8'hF0)) m_dst = 1;
            else if (dst_rev) m_dst = 0;
            if (pwr_up && main_lost && batt_lost) m_lost = 1;
            else if (host_wr && host_addr < 8) m_lost = 0;
            m_s2 = m_s1;
            m_s1 = {on_batt, main_low_raw, batt_warn_raw, batt_crit_raw};
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp;
            exp = (m_mode == 1) ? m_snap : 8'h00;
            n_cmp++;
            if (host_rdata !== exp) begin
                n_bad++;
                $display("FAIL %s: rdata=%02h expected=%02h at cycle %0d", phase, host_rdata, exp, cyc);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic status_read(input int hold);
        @(negedge clk); host_rd = 1; host_addr = 8'h08;
        tick(hold);
        host_rd = 0;
        tick(3);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1: reset state, observed through an explicit read
        phase = "R1 reset";
        @(negedge clk); host_rd = 1; host_addr = 8'h08;
        tick(2);
        n_cmp++;
        if (host_rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset read: rdata=%02h expected=00", host_rdata);
        end
        host_rd = 0; tick(3);

        // R11: levels through synchronizer, battery mode gating, writes ignored
        phase = "R11 levels";
        on_batt = 1; main_low_raw = 1; batt_crit_raw = 1;
        tick(4); status_read(2);
        batt_bus_en = 1; tick(1); status_read(2);
        host_write(8'h08, 8'h00); status_read(2);
        main_low_raw = 0; batt_warn_raw = 1; on_batt = 0;
        tick(1); status_read(2);
        batt_warn_raw = 0; batt_crit_raw = 0;

        // R2 / R3: set by match, clear by zero, write of one cannot set
        phase = "R2 alarm set";
        @(negedge clk); alarm_hit = 2'b01; @(negedge clk); alarm_hit = 0;
        status_read(2);
        phase = "R3 write one keeps";
        host_write(8'h08, 8'hFF); status_read(2);
        phase = "R3 write zero clears";
        host_write(8'h08, 8'hEF); status_read(2);
        host_write(8'h08, 8'h30); status_read(2);

        // R4: match and clearing write in the same cycle
        phase = "R4 set beats write clear";
        @(negedge clk); alarm_hit = 2'b10; host_wr = 1; host_addr = 8'h08; host_wdata = 8'h00;
        @(negedge clk); alarm_hit = 0; host_wr = 0;
        status_read(2);

        // R5: read without auto-clear keeps alarms, holds snapshot for long read
        phase = "R5 plain read";
        auto_clr_en = 0;
        @(negedge clk); host_rd = 1; host_addr = 8'h08;
        tick(1); alarm_hit = 2'b01; tick(1); alarm_hit = 0; tick(4);
        host_rd = 0; tick(3);
        status_read(1);

        // R6: auto-clear wipes snapshotted alarms only
        phase = "R6 auto clear";
        auto_clr_en = 1;
        status_read(2);
        status_read(2);
        @(negedge clk); alarm_hit = 2'b01; @(negedge clk); alarm_hit = 0;
        phase = "R6 match during read survives";
        @(negedge clk); host_rd = 1; host_addr = 8'h08;
        tick(1); alarm_hit = 2'b10; tick(1); alarm_hit = 0; tick(1);
        host_rd = 0; tick(3);
        status_read(2);
        status_read(2);
        // R4 / R6: match in the retire cycle wins over auto-clear
        phase = "R4 set beats auto clear";
        @(negedge clk); alarm_hit = 2'b01; @(negedge clk); alarm_hit = 0;
        @(negedge clk); host_rd = 1; host_addr = 8'h08;
        tick(2); host_rd = 0;
        tick(1); alarm_hit = 2'b01; tick(1); alarm_hit = 0; tick(2);
        status_read(2);
        auto_clr_en = 0;

        // R7: DST events and enable
        phase = "R7 dst events";
        dst_enable = 1;
        @(negedge clk); dst_fwd = 1; @(negedge clk); dst_fwd = 0;
        status_read(2);
        @(negedge clk); dst_rev = 1; @(negedge clk); dst_rev = 0;
        status_read(2);
        @(negedge clk); dst_fwd = 1; dst_rev = 1; @(negedge clk); dst_fwd = 0; dst_rev = 0;
        status_read(2);
        dst_enable = 0; tick(1); status_read(2);
        @(negedge clk); dst_fwd = 1; @(negedge clk); dst_fwd = 0;
        status_read(2);

        // R8: force code
        phase = "R8 force code";
        host_write(8'h08, 8'hF0); status_read(2);
        dst_enable = 1;
        host_write(8'h08, 8'hF1); status_read(2);
        host_write(8'h08, 8'hF0); status_read(2);
        dst_enable = 0; tick(1); status_read(2);

        // R9: total-loss power-up
        phase = "R9 partial loss";
        main_lost = 1;
        @(negedge clk); pwr_up = 1; @(negedge clk); pwr_up = 0;
        status_read(2);
        main_lost = 0; batt_lost = 1;
        @(negedge clk); pwr_up = 1; @(negedge clk); pwr_up = 0;
        status_read(2);
        phase = "R9 total loss";
        main_lost = 1;
        @(negedge clk); pwr_up = 1; @(negedge clk); pwr_up = 0;
        status_read(2);

        // R10: cleared by a timekeeping write only
        phase = "R10 other address";
        host_write(8'h0A, 8'h55); status_read(2);
        host_write(8'h08, 8'hFF); status_read(2);
        phase = "R10 time write";
        host_write(8'h03, 8'h12); status_read(2);
        phase = "R10 set beats clear";
        @(negedge clk); pwr_up = 1; host_wr = 1; host_addr = 8'h00; host_wdata = 8'h01;
        @(negedge clk); pwr_up = 0; host_wr = 0;
        status_read(2);
        host_write(8'h07, 8'h00); status_read(2);
        main_lost = 0; batt_lost = 0;

        tick(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule